// File: doc/BRIEF.md
# USB Start-of-Frame Scheduler

This block paces start-of-frame (SOF) tokens for a USB host. Software first asks for one SOF by hand. From then on the block is in the frame-active state. On every 1 ms frame tick it asks the packet sender for a new SOF carrying the current 11-bit frame number, and after each one the frame number moves up by one. The block does not serialise anything. It only decides when an SOF goes out, which number it carries, and when an ordinary token from software may reach the sender.

Inside each frame a bit-time counter is loaded at the SOF point. The load value is 12000 bit times at full speed and 1500 at low speed, and the counter steps down on every bit-time tick. When the counter equals the programmed guard length, an end-of-frame guard window opens. A token requested inside that window is held and handed to the sender in the cycle right after the SOF request. At a frame tick the sender may still be busy. In that case the SOF is skipped, a sticky lost-SOF flag is raised, and the frame number still advances.

The state machine has four states:
- `ST_IDLE`: frame-active is low.
- `ST_RUN`: active, outside the guard window.
- `ST_GUARD`: active, inside the guard window.
- `ST_POST`: the single cycle after an SOF was issued or skipped.

Its transitions:
- IDLE→POST on an accepted software SOF.
- RUN→GUARD when the counter equals the guard length.
- RUN/GUARD→POST on a frame tick.
- POST→RUN on the next cycle.
- RUN/GUARD/POST→IDLE on any stop condition.

Top module: `sof_frame_sched`

## Requirements
- R1: After reset, frame-active, lost-SOF, `sof_go`, `sof_cmp` and `tok_go` are 0, and the frame number is 0.
- R2: In idle, a `sw_sof_req` with no stop condition present gives a one-cycle `sof_go` with `sof_cmp`=1 in the next cycle. That pulse carries the old frame number on `sof_num`. In the same cycle frame-active becomes 1 and the frame number increments.
- R3: While frame-active, a `frame_tick` with `tx_busy` low gives `sof_go` in the next cycle with `sof_cmp`=0 and `sof_num` equal to the frame number. The frame number increments in that same cycle.
- R4: The frame number wraps from 2047 to 0.
- R5: A token requested while frame-active is held when either of these holds: the bit counter equals `guard_len` at the sampling edge, or the guard window is already open. The held token is given on `tok_go` in the cycle right after the next `sof_go`. `tok_go` and `sof_go` are never high in the same cycle.
- R6: A token requested in idle, or in an active cycle outside the guard window with no frame tick, gives `tok_go` one cycle later.
- R7: A `frame_tick` while active with `tx_busy` high gives no `sof_go`. It sets lost-SOF and still increments the frame number.
- R8: Lost-SOF is sticky. `lost_clr` clears it, and a skip in the same cycle wins over the clear.
- R9: Each of the following clears frame-active in the next cycle, after which no SOF is requested: `active_clr`, `bus_reset`, `suspend`, or `connected` low. A held token is released on `tok_go` at that clearing edge.
- R10: `frame_wr` loads `frame_wdata` into the frame number unless an SOF is issued or skipped in the same cycle.
- R11: `sw_sof_req` is ignored while frame-active, and also while any stop condition is present.
- R12: The bit counter is loaded with 1500 when `low_speed`=1 and 12000 when it is 0. The load happens at each issued or skipped SOF and takes the speed at that edge. A token sampled when the counter equals `guard_len`+1 passes; one sampled when it equals `guard_len` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse every 1 ms |
| bit_tick | input | 1 | One-cycle pulse per bus bit time |
| low_speed | input | 1 | 1 selects low-speed frame length |
| guard_len | input | GUARD_W | Guard window length in bit times |
| tok_req | input | 1 | Software token request pulse |
| tx_busy | input | 1 | Packet sender still transmitting |
| sw_sof_req | input | 1 | Software request for the first SOF |
| frame_wr | input | 1 | Frame number write strobe |
| frame_wdata | input | 11 | Frame number write value |
| active_clr | input | 1 | Software clear of frame-active |
| bus_reset | input | 1 | Bus reset commanded |
| suspend | input | 1 | Suspend set |
| connected | input | 1 | Device attached |
| lost_clr | input | 1 | Clear of the lost-SOF flag |
| sof_go | output | 1 | SOF request pulse to the sender |
| sof_cmp | output | 1 | Completion flag set, software SOF only |
| sof_num | output | 11 | Frame number carried by the SOF |
| tok_go | output | 1 | Token release pulse to the sender |
| frame_active | output | 1 | Automatic SOF generation enabled |
| lost_sof | output | 1 | Sticky skipped-SOF error |
| frame_num | output | 11 | Current frame number |

## Verification
On every cycle, the bound properties check several relations:
- `sof_num` and `frame_num` agree whenever an SOF goes out.
- SOF and token releases never coincide.
- Stop conditions drop frame-active.
- A busy sender at a frame tick suppresses the SOF.
- The lost flag stays set until cleared.
- The completion flag only rides on an SOF.

Some properties need the bench's scenarios to show them. These are the exact guard-window edge relative to the frame length at each speed, and that a held token reaches the sender in precisely the cycle after the SOF. The same holds for the frame number sequence through the 2047 wrap and skipped frames, and for the release of a held token when the frame is stopped.

// File: rtl/sof_pkg.sv
package sof_pkg;
    localparam int FN_W = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_GUARD = 2'd2,
        ST_POST  = 2'd3
    } sched_state_t;
endpackage

// File: rtl/sof_bit_timer.sv
module sof_bit_timer #(
    parameter int FS_BITS = 12000,
    parameter int LS_BITS = 1500,
    parameter int GUARD_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload,
    input  logic               low_speed,
    input  logic               bit_tick,
    input  logic [GUARD_W-1:0] guard_len,
    output logic               guard_hit
);
    localparam int MAXB = (FS_BITS > LS_BITS) ? FS_BITS : LS_BITS;
    localparam int RW   = $clog2(MAXB + 1);
    localparam int CW   = (RW > GUARD_W) ? RW : GUARD_W;
    localparam logic [RW-1:0] FS_LEN = RW'(FS_BITS);
    localparam logic [RW-1:0] LS_LEN = RW'(LS_BITS);

    logic [RW-1:0] remain;

    // remaining bit times until the next SOF point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (reload) begin
            remain <= low_speed ? LS_LEN : FS_LEN;
        end else if (bit_tick && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign guard_hit = (CW'(remain) == CW'(guard_len));
endmodule

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr #(
    parameter int FN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            capture,
    input  logic            load,
    input  logic [FN_W-1:0] load_val,
    output logic [FN_W-1:0] num,
    output logic [FN_W-1:0] sent_num
);
    // frame number, natural wrap at 2**FN_W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num <= '0;
        end else if (step) begin
            num <= num + 1'b1;
        end else if (load) begin
            num <= load_val;
        end
    end

    // number carried by the SOF being issued
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_num <= '0;
        end else if (capture) begin
            sent_num <= num;
        end
    end
endmodule

// File: rtl/sof_sched_fsm.sv
module sof_sched_fsm
    import sof_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic tok_req,
    input  logic tx_busy,
    input  logic sw_sof_req,
    input  logic stop,
    input  logic guard_hit,
    input  logic lost_clr,
    output logic step,
    output logic capture,
    output logic sof_go,
    output logic sof_cmp,
    output logic tok_go,
    output logic frame_active,
    output logic lost_sof
);
    sched_state_t state, st_n;
    logic do_sof, do_skip, sw_src, hold;
    logic pend, pend_n, tok_go_n;

    // next state and strobes
    always_comb begin
        st_n    = state;
        do_sof  = 1'b0;
        do_skip = 1'b0;
        sw_src  = 1'b0;
        hold    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sw_sof_req && !stop) begin
                    do_sof = 1'b1;
                    sw_src = 1'b1;
                    hold   = 1'b1;
                    st_n   = ST_POST;
                end
            end
            ST_RUN, ST_GUARD: begin
                if (stop) begin
                    st_n = ST_IDLE;
                end else if (frame_tick) begin
                    hold = 1'b1;
                    if (tx_busy) do_skip = 1'b1;
                    else         do_sof  = 1'b1;
                    st_n = ST_POST;
                end else if ((state == ST_GUARD) || guard_hit) begin
                    hold = 1'b1;
                    st_n = ST_GUARD;
                end else begin
                    st_n = ST_RUN;
                end
            end
            ST_POST: begin
                st_n = stop ? ST_IDLE : ST_RUN;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // token path: hold or drain one token per cycle
    always_comb begin
        if (hold) begin
            tok_go_n = 1'b0;
            pend_n   = pend | tok_req;
        end else begin
            tok_go_n = pend | tok_req;
            pend_n   = pend & tok_req;
        end
    end

    assign step    = do_sof | do_skip;
    assign capture = do_sof;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_go       <= 1'b0;
            sof_cmp      <= 1'b0;
            tok_go       <= 1'b0;
            pend         <= 1'b0;
            frame_active <= 1'b0;
            lost_sof     <= 1'b0;
        end else begin
            sof_go       <= do_sof;
            sof_cmp      <= do_sof & sw_src;
            tok_go       <= tok_go_n;
            pend         <= pend_n;
            frame_active <= (st_n != ST_IDLE);
            if (do_skip)       lost_sof <= 1'b1;
            else if (lost_clr) lost_sof <= 1'b0;
        end
    end
endmodule

// File: rtl/sof_frame_sched.sv
module sof_frame_sched
    import sof_pkg::*;
#(
    parameter int FS_BITS = 12000,
    parameter int LS_BITS = 1500,
    parameter int GUARD_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic               bit_tick,
    input  logic               low_speed,
    input  logic [GUARD_W-1:0] guard_len,
    input  logic               tok_req,
    input  logic               tx_busy,
    input  logic               sw_sof_req,
    input  logic               frame_wr,
    input  logic [FN_W-1:0]    frame_wdata,
    input  logic               active_clr,
    input  logic               bus_reset,
    input  logic               suspend,
    input  logic               connected,
    input  logic               lost_clr,
    output logic               sof_go,
    output logic               sof_cmp,
    output logic [FN_W-1:0]    sof_num,
    output logic               tok_go,
    output logic               frame_active,
    output logic               lost_sof,
    output logic [FN_W-1:0]    frame_num
);
    logic stop, guard_hit, step, capture;

    assign stop = active_clr | bus_reset | suspend | ~connected;

    sof_bit_timer #(
        .FS_BITS(FS_BITS),
        .LS_BITS(LS_BITS),
        .GUARD_W(GUARD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (step),
        .low_speed(low_speed),
        .bit_tick (bit_tick),
        .guard_len(guard_len),
        .guard_hit(guard_hit)
    );

    sof_frame_ctr #(.FN_W(FN_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .capture (capture),
        .load    (frame_wr),
        .load_val(frame_wdata),
        .num     (frame_num),
        .sent_num(sof_num)
    );

    sof_sched_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .tok_req     (tok_req),
        .tx_busy     (tx_busy),
        .sw_sof_req  (sw_sof_req),
        .stop        (stop),
        .guard_hit   (guard_hit),
        .lost_clr    (lost_clr),
        .step        (step),
        .capture     (capture),
        .sof_go      (sof_go),
        .sof_cmp     (sof_cmp),
        .tok_go      (tok_go),
        .frame_active(frame_active),
        .lost_sof    (lost_sof)
    );
endmodule

// File: rtl/sof_frame_sched_chk.sv
module sof_frame_sched_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_tick,
    input logic        tx_busy,
    input logic        sw_sof_req,
    input logic        active_clr,
    input logic        bus_reset,
    input logic        suspend,
    input logic        connected,
    input logic        lost_clr,
    input logic        sof_go,
    input logic        sof_cmp,
    input logic [10:0] sof_num,
    input logic        tok_go,
    input logic        frame_active,
    input logic        lost_sof,
    input logic [10:0] frame_num
);
    logic stop_c;
    assign stop_c = active_clr | bus_reset | suspend | ~connected;

    // R3
    sof_num_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_go |-> (frame_num == 11'(sof_num + 11'd1)));

    // R5
    sof_tok_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_go && tok_go));

    // R9
    stop_drops_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !frame_active);

    // R7
    busy_skips_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && frame_tick && tx_busy && !stop_c) |=> !sof_go);

    // R8
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_sof && !lost_clr) |=> lost_sof);

    // R11
    sw_sof_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && sw_sof_req && stop_c) |=> !sof_go);

    // R2
    cmp_with_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_cmp |-> (sof_go && frame_active));
endmodule

bind sof_frame_sched sof_frame_sched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .tx_busy     (tx_busy),
    .sw_sof_req  (sw_sof_req),
    .active_clr  (active_clr),
    .bus_reset   (bus_reset),
    .suspend     (suspend),
    .connected   (connected),
    .lost_clr    (lost_clr),
    .sof_go      (sof_go),
    .sof_cmp     (sof_cmp),
    .sof_num     (sof_num),
    .tok_go      (tok_go),
    .frame_active(frame_active),
    .lost_sof    (lost_sof),
    .frame_num   (frame_num)
);

// File: tb/tb_sof_frame_sched.sv
module tb_sof_frame_sched;
    localparam int LS = 1500;
    localparam int FS = 12000;
    localparam int G  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 0, bit_tick = 1, low_speed = 1;
    logic [13:0] guard_len = 14'(G);
    logic tok_req = 0, tx_busy = 0, sw_sof_req = 0, frame_wr = 0;
    logic [10:0] frame_wdata = '0;
    logic active_clr = 0, bus_reset = 0, suspend = 0, connected = 1, lost_clr = 0;
    logic sof_go, sof_cmp, tok_go, frame_active, lost_sof;
    logic [10:0] sof_num, frame_num;

    always #2.5 clk = ~clk;

    sof_frame_sched dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bit_tick(bit_tick),
        .low_speed(low_speed), .guard_len(guard_len), .tok_req(tok_req),
        .tx_busy(tx_busy), .sw_sof_req(sw_sof_req), .frame_wr(frame_wr),
        .frame_wdata(frame_wdata), .active_clr(active_clr), .bus_reset(bus_reset),
        .suspend(suspend), .connected(connected), .lost_clr(lost_clr),
        .sof_go(sof_go), .sof_cmp(sof_cmp), .sof_num(sof_num), .tok_go(tok_go),
        .frame_active(frame_active), .lost_sof(lost_sof), .frame_num(frame_num)
    );

    typedef struct {
        int    kind;   // 0 SOF, 1 token, 2 token right after SOF
        int    num;
        int    cmp;
        string req;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int fn = 0;
    bit prev_sof = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_sof(input int cmp, input string req);
        exp_q.push_back('{0, fn, cmp, req});
        fn = (fn + 1) % 2048;
    endtask

    task automatic push_tok(input int kind, input string req);
        exp_q.push_back('{kind, 0, 0, req});
    endtask

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sof_go) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected sof", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk({it.req, " kind"}, 0, it.kind);
                    chk({it.req, " sof_num"}, int'(sof_num), it.num);
                    chk({it.req, " sof_cmp"}, int'(sof_cmp), it.cmp);
                end
            end
            if (tok_go) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected tok", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk({it.req, " kind"}, (it.kind == 0) ? 0 : it.kind, it.kind == 0 ? 1 : it.kind);
                    if (it.kind == 2) chk({it.req, " after sof"}, int'(prev_sof), 1);
                    if (it.kind == 1) chk({it.req, " not after sof"}, int'(prev_sof), 0);
                end
            end
            prev_sof = sof_go;
        end
    end

    task automatic run_frame(input int len, input int tok_at, input int sw_at,
                             input int clr_at, input int stop_at, input bit busy,
                             input bit fire);
        for (int c = 0; c < len; c++) begin
            tok_req    = (c == tok_at);
            sw_sof_req = (c == sw_at);
            lost_clr   = (c == clr_at);
            active_clr = (c == stop_at);
            frame_tick = fire && (c == len - 1);
            tx_busy    = busy && (c == len - 1);
            @(negedge clk);
        end
        tok_req = 0; sw_sof_req = 0; lost_clr = 0; active_clr = 0;
        frame_tick = 0; tx_busy = 0;
    endtask

    task automatic sw_start(input string req);
        push_sof(1, req);
        sw_sof_req = 1;
        @(negedge clk);
        sw_sof_req = 0;
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 frame_active", int'(frame_active), 0);
        chk("R1 lost_sof", int'(lost_sof), 0);
        chk("R1 frame_num", int'(frame_num), 0);
        chk("R1 sof_go", int'(sof_go), 0);
        chk("R1 tok_go", int'(tok_go), 0);
        rst_n = 1;
        @(negedge clk);

        // R10 frame number write
        frame_wdata = 11'd2046; frame_wr = 1;
        @(negedge clk);
        frame_wr = 0;
        chk("R10 frame_num load", int'(frame_num), 2046);
        fn = 2046;

        // R6 token while idle
        push_tok(1, "R6 idle tok");
        tok_req = 1; @(negedge clk); tok_req = 0;
        @(negedge clk);

        // R2 software SOF
        sw_start("R2 sw sof");
        chk("R2 frame_active", int'(frame_active), 1);
        chk("R2 frame_num", int'(frame_num), 2047);

        // frame 1: token outside guard passes, sw SOF ignored (R11)
        push_tok(1, "R6 run tok");
        push_sof(0, "R3 auto sof");
        run_frame(LS, 5, 10, -1, -1, 0, 1);
        chk("R4 wrap", int'(frame_num), 0);

        // frame 2: token one bit before the guard passes (R12)
        push_tok(1, "R12 pre-guard tok");
        push_sof(0, "R3 auto sof");
        run_frame(LS, LS - G - 1, -1, -1, -1, 0, 1);

        // frame 3: token at the guard edge is held (R5)
        push_sof(0, "R5 sof before held tok");
        push_tok(2, "R5 held tok");
        run_frame(LS, LS - G, -1, -1, -1, 0, 1);
        chk("R3 frame_num", int'(frame_num), 2);

        // frame 4: busy sender skips the SOF (R7)
        run_frame(LS, -1, -1, -1, -1, 1, 1);
        fn = (fn + 1) % 2048;
        chk("R7 lost_sof", int'(lost_sof), 1);
        chk("R7 frame_num", int'(frame_num), 3);

        // frame 5: skip and clear together, set wins (R8)
        run_frame(LS, -1, -1, LS - 1, -1, 1, 1);
        fn = (fn + 1) % 2048;
        chk("R8 set wins", int'(lost_sof), 1);

        // frame 6: clear lost, switch to full speed for next frame
        low_speed = 0;
        push_sof(0, "R3 auto sof");
        run_frame(LS, -1, -1, 3, -1, 0, 1);
        chk("R8 cleared", int'(lost_sof), 0);

        // frame 7: full-speed length, held token at guard edge (R12)
        low_speed = 1;
        push_sof(0, "R12 full-speed sof");
        push_tok(2, "R12 full-speed held tok");
        run_frame(FS, FS - G, -1, -1, -1, 0, 1);
        chk("R12 frame_num", int'(frame_num), 6);

        // frame 8: held token released by active_clr (R9)
        push_tok(1, "R9 released tok");
        run_frame(LS - 4, LS - G, -1, -1, LS - 5, 0, 0);
        chk("R9 active_clr", int'(frame_active), 0);
        run_frame(20, -1, -1, -1, -1, 0, 1);
        chk("R9 no sof after stop", int'(frame_num), 6);

        // R9 other stop sources
        sw_start("R2 restart");
        repeat (3) @(negedge clk);
        bus_reset = 1; @(negedge clk); bus_reset = 0;
        chk("R9 bus_reset", int'(frame_active), 0);
        sw_start("R2 restart");
        repeat (3) @(negedge clk);
        suspend = 1; @(negedge clk); suspend = 0;
        chk("R9 suspend", int'(frame_active), 0);
        sw_start("R2 restart");
        repeat (3) @(negedge clk);
        connected = 0; @(negedge clk); connected = 1;
        chk("R9 disconnect", int'(frame_active), 0);

        // R11 software SOF with stop present
        suspend = 1; sw_sof_req = 1; @(negedge clk);
        sw_sof_req = 0; @(negedge clk); suspend = 0;
        chk("R11 blocked sw sof", int'(frame_active), 0);
        chk("R11 frame_num", int'(frame_num), 9);

        repeat (5) @(negedge clk);
        chk("R3 all expected seen", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule